// File: doc/BRIEF.md
# Stereo DAC Silence Detector and Mute Gate

This block sits in the digital path of a stereo sigma-delta DAC, between the serial receiver that assembles the sample words and the interpolation filter. A single-cycle frame strobe marks each new pair of 16-bit two's-complement samples. The block passes each pair through, except in two cases. It replaces a channel's sample with the common-level code (mid-scale, 16'h0000 in two's complement) when that channel has carried all-zero data for a long run. It also replaces both samples when the external mute input is high.

Each channel keeps its own count of consecutive all-zero frames. The count is in frame periods, not system clocks. When the run grows past 8192 frames, the channel enters silence mute and raises its flag. The counter saturates, so any length of silence keeps the mute in place. The first non-zero sample on that channel clears the count and releases the mute in that same frame. Outputs and flags are registered and update only at a frame strobe, so a half-updated stereo pair never reaches the filter.

Top module: `zmute_ctrl`

## Requirements
- R1: While `rst_n` is low, both sample outputs read 16'h0000, both flags read 0 and both zero-run counts are cleared.
- R2: When the mute input is low and a channel is not in silence mute, a strobed sample appears unchanged on that channel's output at the clock edge that captures the strobe.
- R3: Outputs and flags change only at a clock edge where `frame_stb` is high. Input changes without a strobe have no effect on them.
- R4: A channel's flag rises, and its output becomes 16'h0000, on the 8193rd consecutive strobed all-zero sample of that channel. After 8192 such samples the flag is still 0.
- R5: The zero run is judged per channel. Non-zero data on one channel neither sets nor clears the other channel's flag or count.
- R6: A strobed non-zero sample on a channel in silence mute clears its flag and its count. That sample is passed to the output in the same frame.
- R7: A strobe with `mute_in` high drives both outputs to the common-level code 16'h0000 whatever the counts are, and leaves the flags and counts unaffected.
- R8: The zero-run count saturates. A silence of 16400 frames, longer than the counter's wrap length, keeps the flag set throughout.
- R9: A reset in the middle of a zero run discards the run. After release, another full run of more than 8192 zero frames is needed before the flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_stb | input | 1 | One-cycle strobe marking a new stereo sample pair |
| left_in | input | 16 | Left sample, two's complement |
| right_in | input | 16 | Right sample, two's complement |
| mute_in | input | 1 | External hard mute, high forces common level |
| left_out | output | 16 | Left sample after muting |
| right_out | output | 16 | Right sample after muting |
| left_zflag | output | 1 | Left channel is in silence mute |
| right_zflag | output | 1 | Right channel is in silence mute |

## Verification
Every result of this block is due exactly one clock edge after the strobe that carries its sample pair. That covers the passed sample, a hard-mute substitution, the rise of a silence flag on the 8193rd zero frame and its release on the first non-zero one. The driver raises the strobe on a falling edge and queues the expected pair and flags from its own per-channel run model. The monitor pops and compares on the falling edge after the capturing rising edge. Between strobes the bench changes the inputs and checks that the outputs still equal the last expected values. Reset is checked while it is held low.

// File: rtl/zmute_pkg.sv
package zmute_pkg;

  localparam int N_CH = 2;

  typedef enum logic [0:0] {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } zm_ch_e;

  // Output selection: forced code when any mute source is active.
  function automatic logic [15:0] zm_pick(
    input logic        force_mute,
    input logic [15:0] sample,
    input logic [15:0] common_code
  );
    return force_mute ? common_code : sample;
  endfunction

endpackage

// File: rtl/zmute_run_cnt.sv
module zmute_run_cnt #(
  parameter int ZERO_RUN = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic is_zero,
  output logic auto_d,
  output logic auto_q
);

  localparam int                CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(ZERO_RUN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    auto_d = auto_q;
    if (stb) begin
      if (!is_zero) begin
        cnt_d  = '0;
        auto_d = 1'b0;
      end else if (cnt_q == LIMIT) begin
        auto_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers, enabled by the frame strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      auto_q <= 1'b0;
    end else if (stb) begin
      cnt_q  <= cnt_d;
      auto_q <= auto_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R8

  AST_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q |-> (cnt_q == LIMIT)); // R4

  AST_RELEASE_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(auto_q) |-> $past(stb && !is_zero)); // R6

  AST_RISE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_q) |-> $past(stb && is_zero)); // R3

endmodule

// File: rtl/zmute_chan.sv
module zmute_chan #(
  parameter int          SMP_W     = 16,
  parameter int          ZERO_RUN  = 8192,
  parameter logic [15:0] MID_CODE  = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [SMP_W-1:0] smp_in,
  input  logic             hard_mute,
  output logic [SMP_W-1:0] smp_out,
  output logic             zflag
);

  logic             is_zero;
  logic             auto_d;
  logic             auto_q;
  logic [SMP_W-1:0] out_d;
  logic [SMP_W-1:0] out_q;

  assign is_zero = (smp_in == '0);

  zmute_run_cnt #(.ZERO_RUN(ZERO_RUN)) u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .is_zero(is_zero),
    .auto_d (auto_d),
    .auto_q (auto_q)
  );

  always_comb begin
    out_d = out_q;
    if (stb)
      out_d = SMP_W'(zmute_pkg::zm_pick(hard_mute | auto_d,
                                         16'(smp_in), MID_CODE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_q <= '0;
    else if (stb)
      out_q <= out_d;
  end

  assign smp_out = out_q;
  assign zflag   = auto_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(out_q)); // R3

  AST_HARD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && hard_mute) |=> (out_q == SMP_W'(MID_CODE))); // R7

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !hard_mute && !is_zero) |=> (out_q == $past(smp_in))); // R6

endmodule

// File: rtl/zmute_ctrl.sv
module zmute_ctrl #(
  parameter int          SMP_W    = 16,
  parameter int          ZERO_RUN = 8192,
  parameter logic [15:0] MID_CODE = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [SMP_W-1:0] left_in,
  input  logic [SMP_W-1:0] right_in,
  input  logic             mute_in,
  output logic [SMP_W-1:0] left_out,
  output logic [SMP_W-1:0] right_out,
  output logic             left_zflag,
  output logic             right_zflag
);

  import zmute_pkg::*;

  logic [SMP_W-1:0] smp_in_a  [N_CH];
  logic [SMP_W-1:0] smp_out_a [N_CH];
  logic             zflag_a   [N_CH];

  assign smp_in_a[CH_LEFT]  = left_in;
  assign smp_in_a[CH_RIGHT] = right_in;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    zmute_chan #(
      .SMP_W   (SMP_W),
      .ZERO_RUN(ZERO_RUN),
      .MID_CODE(MID_CODE)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (frame_stb),
      .smp_in   (smp_in_a[ch]),
      .hard_mute(mute_in),
      .smp_out  (smp_out_a[ch]),
      .zflag    (zflag_a[ch])
    );
  end

  assign left_out    = smp_out_a[CH_LEFT];
  assign right_out   = smp_out_a[CH_RIGHT];
  assign left_zflag  = zflag_a[CH_LEFT];
  assign right_zflag = zflag_a[CH_RIGHT];

  AST_FLAG_STB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(left_zflag) && $stable(right_zflag))); // R3

  AST_FLAG_MUTES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    left_zflag |-> (left_out == SMP_W'(MID_CODE))); // R4

endmodule

// File: tb/sim_zmute_ctrl.sv
module sim_zmute_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_stb;
  logic [15:0] left_in, right_in;
  logic        mute_in;
  logic [15:0] left_out, right_out;
  logic        left_zflag, right_zflag;

  always #2.5 clk = ~clk;

  zmute_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .left_in(left_in), .right_in(right_in), .mute_in(mute_in),
    .left_out(left_out), .right_out(right_out),
    .left_zflag(left_zflag), .right_zflag(right_zflag)
  );

  typedef struct {
    logic [15:0] l;
    logic [15:0] r;
    logic        fl;
    logic        fr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk  = 0;
  int n_fail = 0;
  int zl = 0, zr = 0;
  logic [15:0] last_l = '0, last_r = '0;
  logic        last_fl = 1'b0, last_fr = 1'b0;
  logic        seen = 1'b0;
  int          cyc = 0;

  task automatic compare(input string tag, input logic [15:0] l, input logic [15:0] r,
                         input logic fl, input logic fr);
    n_chk++;
    if (left_out !== l || right_out !== r || left_zflag !== fl || right_zflag !== fr) begin
      n_fail++;
      $display("FAIL %s: got L=%h R=%h fl=%b fr=%b, expected L=%h R=%h fl=%b fr=%b",
               tag, left_out, right_out, left_zflag, right_zflag, l, r, fl, fr);
    end
  endtask

  // driver: one frame, with the expected result from the bench's own run model
  task automatic frame(input logic [15:0] l, input logic [15:0] r, input logic m,
                       input string tag);
    exp_t e;
    @(negedge clk);
    left_in = l; right_in = r; mute_in = m; frame_stb = 1'b1;
    zl = (l == 16'h0) ? zl + 1 : 0;
    zr = (r == 16'h0) ? zr + 1 : 0;
    e.fl  = (zl > 8192);
    e.fr  = (zr > 8192);
    e.l   = (m || e.fl) ? 16'h0000 : l;
    e.r   = (m || e.fr) ? 16'h0000 : r;
    e.tag = tag;
    last_l = e.l; last_r = e.r; last_fl = e.fl; last_fr = e.fr;
    q.push_back(e);
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_stb = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset", 16'h0, 16'h0, 1'b0, 1'b0);
    zl = 0; zr = 0;
    last_l = '0; last_r = '0; last_fl = 1'b0; last_fr = 1'b0;
    rst_n = 1'b1;
  endtask

  // no strobe: wiggle inputs and mute, outputs must hold
  task automatic idle_check(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      left_in = 16'h1234 + 16'(i); right_in = 16'h0; mute_in = i[0];
      @(negedge clk);
      compare(tag, last_l, last_r, last_fl, last_fr);
    end
    mute_in = 1'b0;
  endtask

  // monitor
  always @(posedge clk) seen <= frame_stb && rst_n;
  always @(negedge clk) begin
    if (seen && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.tag, e.l, e.r, e.fl, e.fr);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected completion earlier", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; frame_stb = 1'b0; left_in = '0; right_in = '0; mute_in = 1'b0;
    do_reset();

    frame(16'h1234, 16'hFEDC, 1'b0, "R2 pass");
    frame(16'h8000, 16'h7FFF, 1'b0, "R2 full scale");
    frame(16'h0001, 16'hFFFF, 1'b0, "R2 small");
    idle_check("R3 no strobe");

    frame(16'h5555, 16'hAAAA, 1'b1, "R7 hard mute");
    frame(16'h0F0F, 16'h0003, 1'b1, "R7 hard mute");
    frame(16'h0F0F, 16'h0003, 1'b0, "R7 mute released");

    for (int i = 1; i <= 8192; i++) frame(16'h0, 16'h0, 1'b0, "R4 run below limit");
    frame(16'h0, 16'h0, 1'b0, "R4 8193rd zero");
    idle_check("R3 hold in mute");

    frame(16'h0042, 16'h0, 1'b0, "R6 release left");
    frame(16'h0043, 16'h0, 1'b0, "R5 right stays muted");
    for (int i = 0; i < 16400; i++) frame(16'h0077, 16'h0, 1'b0, "R8 long silence");
    frame(16'h0077, 16'h0, 1'b1, "R7 mute with flag");
    frame(16'h0077, 16'h0, 1'b0, "R7 flag unaffected");
    frame(16'h0, 16'h2222, 1'b0, "R6 release right");

    for (int i = 0; i < 8000; i++) frame(16'h0, 16'h0, 1'b0, "R9 pre-reset run");
    do_reset();
    for (int i = 0; i < 300; i++) frame(16'h0, 16'h0, 1'b0, "R9 run restarted");

    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule